// File: doc/BRIEF.md
# Landing-Pad Expectation Tracker

This block keeps the single bit that says whether the next instruction must be a landing pad, together with the copies of that bit that traps and debug entry save. An indirect jump that retires in a privilege mode with landing pads enabled sets the bit. The next instruction then either clears it by being a landing pad, or draws a software-check exception request. The request carries cause 18 and trap value 2.

Trap entry can land between the jump and its target. So any trap entry, including entry into debug, stores the live bit into the copy that belongs to the handling level and then clears the live bit. A return instruction from that level (machine return, non-maskable-interrupt return, supervisor return, virtual-supervisor return, debug resume) restores the copy into the live bit only if the mode being returned to has landing pads enabled. The return then zeroes the copy.

The unit only takes part in exception arbitration where its own exception sits. It yields to an instruction-fetch access fault and it overrides an illegal-instruction report.

Top module: `landing_pad_tracker`

## Requirements
- R1: After reset the live bit is 0 and all four saved copies are 0. A return from any level then leaves the live bit at 0, and no exception is requested.
- R2: A retiring indirect jump (`retire_vld` and `retire_ind_jump`) sets the live bit on the next clock when `lpe_en[cur_mode]` is 1, and leaves it at 0 when that enable is 0. Mode codes index `lpe_en`: U=0, S=1, M=2, VU=3, VS=4. Codes 5 to 7 count as disabled.
- R3: While the live bit is 1, an instruction with `insn_vld` and `insn_is_lpad` raises no request and clears the live bit on the next clock.
- R4: While the live bit is 1, an instruction with `insn_vld` that is not a landing pad raises `swchk_req` in the same cycle. `swchk_cause` is then 18 and `swchk_tval` is 2. With the live bit at 0 there is never a request.
- R5: `insn_fetch_fault` suppresses the request. When the request is raised together with `insn_illegal`, `illegal_squash` is 1. Otherwise `illegal_squash` is 0.
- R6: `trap_vld` with `trap_slot` (M=0, S=1, VS=2) copies the live bit into that slot and clears the live bit on the next clock.
- R7: Debug entry is `trap_vld` with slot 3. It saves into the debug copy in the same way.
- R8: `ret_vld` with `ret_slot` and `ret_dst` sets the live bit to the slot's copy when `lpe_en[ret_dst]` is 1, and to 0 otherwise.
- R9: A return zeroes the copy in the slot it used, so a second return from that slot yields 0.
- R10: Within one cycle, a trap takes precedence over a return. A return takes precedence over arming by a jump, and arming takes precedence over clearing by a landing pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_mode | input | 3 | Current privilege mode code |
| lpe_en | input | 5 | Landing-pad enable per mode code |
| retire_vld | input | 1 | An instruction retires |
| retire_ind_jump | input | 1 | The retiring instruction is an indirect jump |
| insn_vld | input | 1 | An instruction reaches the landing-pad check |
| insn_is_lpad | input | 1 | That instruction is a landing pad |
| insn_fetch_fault | input | 1 | That instruction has a fetch access fault |
| insn_illegal | input | 1 | That instruction is illegal |
| trap_vld | input | 1 | Trap or debug entry |
| trap_slot | input | 2 | Saved-copy slot of the handling level |
| ret_vld | input | 1 | Return instruction or debug resume |
| ret_slot | input | 2 | Saved-copy slot of the level being left |
| ret_dst | input | 3 | Mode code being returned to |
| pad_armed | output | 1 | Live expectation bit |
| swchk_req | output | 1 | Software-check exception request |
| swchk_cause | output | 6 | Exception cause (18) |
| swchk_tval | output | 64 | Exception trap value (2) |
| illegal_squash | output | 1 | The request overrides an illegal-instruction report |

## Verification
On every cycle the assertions check the one-cycle relations: arming after an enabled jump, clearing after a trap or a landing pad, clearing after a return into a disabled mode, the fixed cause and trap value, and the priority slot against fetch faults and illegal instructions. The save-then-restore round trip goes through a hidden copy, so only the bench scenarios can show it. They cover whether the right slot held the right value, whether the copy was zeroed after use, and how same-cycle events combine. The bench reaches these through later returns that expose the copies on `pad_armed`.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int MODE_W      = 3;
    localparam int NUM_MODES   = 5;
    localparam int NUM_SLOTS   = 4;
    localparam int SLOT_W      = $clog2(NUM_SLOTS);
    localparam int SWCHK_CAUSE = 18;
    localparam int LPAD_TVAL   = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_U  = 3'd0,
        MD_S  = 3'd1,
        MD_M  = 3'd2,
        MD_VU = 3'd3,
        MD_VS = 3'd4
    } mode_e;

    typedef enum logic [SLOT_W-1:0] {
        SL_M   = 2'd0,
        SL_S   = 2'd1,
        SL_VS  = 2'd2,
        SL_DBG = 2'd3
    } slot_e;

    typedef struct packed {
        logic armed;
    } live_t;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] copy;
    } bank_t;
endpackage

// File: rtl/lpt_save_bank.sv
module lpt_save_bank
    import lpt_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_en,
    input  logic [IW-1:0]    save_idx,
    input  logic             save_val,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    output logic [SLOTS-1:0] saved
);
    logic [SLOTS-1:0] save_hit;
    logic [SLOTS-1:0] clr_hit;
    logic [SLOTS-1:0] bank_d;
    logic [SLOTS-1:0] bank_q;

    // One-hot decode of the slot addressed by each operation.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign save_hit[g] = save_en && (save_idx == IW'(g));
        assign clr_hit[g]  = clr_en  && (clr_idx  == IW'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (save_hit[i]) begin
                bank_d[i] = save_val;
            end else if (clr_hit[i]) begin
                bank_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign saved = bank_q;
endmodule

// File: rtl/lpt_slot_check.sv
module lpt_slot_check
    import lpt_pkg::*;
#(
    parameter int CAUSE_W = 6,
    parameter int XLEN    = 64
) (
    input  logic               armed,
    input  logic               insn_vld,
    input  logic               insn_is_lpad,
    input  logic               insn_fetch_fault,
    input  logic               insn_illegal,
    output logic               req,
    output logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    tval,
    output logic               squash,
    output logic               pad_seen
);
    logic missing;

    always_comb begin
        // A fetch access fault outranks the missing-pad check.
        pad_seen = armed && insn_vld && insn_is_lpad && !insn_fetch_fault;
        missing  = armed && insn_vld && !insn_is_lpad;
        req      = missing && !insn_fetch_fault;
        // The missing-pad check outranks an illegal-instruction report.
        squash   = req && insn_illegal;
        cause    = req ? CAUSE_W'(SWCHK_CAUSE) : '0;
        tval     = req ? XLEN'(LPAD_TVAL) : '0;
    end
endmodule

// File: rtl/landing_pad_tracker.sv
module landing_pad_tracker
    import lpt_pkg::*;
#(
    parameter int CAUSE_W = 6,
    parameter int XLEN    = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cur_mode,
    input  logic [4:0]         lpe_en,
    input  logic               retire_vld,
    input  logic               retire_ind_jump,
    input  logic               insn_vld,
    input  logic               insn_is_lpad,
    input  logic               insn_fetch_fault,
    input  logic               insn_illegal,
    input  logic               trap_vld,
    input  logic [1:0]         trap_slot,
    input  logic               ret_vld,
    input  logic [1:0]         ret_slot,
    input  logic [2:0]         ret_dst,
    output logic               pad_armed,
    output logic               swchk_req,
    output logic [CAUSE_W-1:0] swchk_cause,
    output logic [XLEN-1:0]    swchk_tval,
    output logic               illegal_squash
);
    localparam int EN_SPAN = 2 ** MODE_W;

    live_t                live_d;
    live_t                live_q;
    logic [EN_SPAN-1:0]   en_pad;
    logic                 arm_hit;
    logic                 pad_seen;
    logic                 save_en;
    logic                 clr_en;
    logic [NUM_SLOTS-1:0] saved;

    lpt_slot_check #(
        .CAUSE_W (CAUSE_W),
        .XLEN    (XLEN)
    ) u_check (
        .armed            (live_q.armed),
        .insn_vld         (insn_vld),
        .insn_is_lpad     (insn_is_lpad),
        .insn_fetch_fault (insn_fetch_fault),
        .insn_illegal     (insn_illegal),
        .req              (swchk_req),
        .cause            (swchk_cause),
        .tval             (swchk_tval),
        .squash           (illegal_squash),
        .pad_seen         (pad_seen)
    );

    lpt_save_bank #(
        .SLOTS (NUM_SLOTS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_en  (save_en),
        .save_idx (trap_slot),
        .save_val (live_q.armed),
        .clr_en   (clr_en),
        .clr_idx  (ret_slot),
        .saved    (saved)
    );

    always_comb begin
        // Unused mode codes read as disabled.
        en_pad                = '0;
        en_pad[NUM_MODES-1:0] = lpe_en;
        arm_hit = retire_vld && retire_ind_jump && en_pad[cur_mode];
        save_en = trap_vld;
        clr_en  = ret_vld && !trap_vld;
        live_d  = live_q;
        if (trap_vld) begin
            live_d.armed = 1'b0;
        end else if (ret_vld) begin
            live_d.armed = saved[ret_slot] && en_pad[ret_dst];
        end else if (arm_hit) begin
            live_d.armed = 1'b1;
        end else if (pad_seen) begin
            live_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    assign pad_armed = live_q.armed;
endmodule

// File: rtl/lpt_checker.sv
module lpt_checker #(
    parameter int CAUSE_W = 6,
    parameter int XLEN    = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         cur_mode,
    input logic [4:0]         lpe_en,
    input logic               retire_vld,
    input logic               retire_ind_jump,
    input logic               insn_vld,
    input logic               insn_is_lpad,
    input logic               insn_fetch_fault,
    input logic               insn_illegal,
    input logic               trap_vld,
    input logic               ret_vld,
    input logic [2:0]         ret_dst,
    input logic               pad_armed,
    input logic               swchk_req,
    input logic [CAUSE_W-1:0] swchk_cause,
    input logic [XLEN-1:0]    swchk_tval,
    input logic               illegal_squash
);
    logic cur_en;
    logic dst_en;

    assign cur_en = (cur_mode < 3'd5) && lpe_en[cur_mode];
    assign dst_en = (ret_dst  < 3'd5) && lpe_en[ret_dst];

    // R2
    arm_on_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && retire_ind_jump && cur_en && !trap_vld && !ret_vld) |=> pad_armed);

    // R3
    pad_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_armed && insn_vld && insn_is_lpad && !insn_fetch_fault
         && !trap_vld && !ret_vld && !(retire_vld && retire_ind_jump)) |=> !pad_armed);

    // R3
    pad_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_vld && insn_is_lpad) |-> !swchk_req);

    // R4
    req_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swchk_req |-> (swchk_cause == CAUSE_W'(18) && swchk_tval == XLEN'(2)));

    // R4
    req_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swchk_req |-> (pad_armed && insn_vld));

    // R5
    fetch_fault_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_fetch_fault |-> !swchk_req);

    // R5
    squash_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_squash |-> (swchk_req && insn_illegal));

    // R6
    trap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_vld |=> !pad_armed);

    // R8
    ret_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_vld && !trap_vld && !dst_en) |=> !pad_armed);
endmodule

bind landing_pad_tracker lpt_checker #(
    .CAUSE_W (CAUSE_W),
    .XLEN    (XLEN)
) u_chk (.*);

// File: tb/landing_pad_tracker_tb.sv
module landing_pad_tracker_tb;
    localparam int CW = 6;
    localparam int XW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cur_mode;
    logic [4:0]    lpe_en;
    logic          retire_vld, retire_ind_jump;
    logic          insn_vld, insn_is_lpad, insn_fetch_fault, insn_illegal;
    logic          trap_vld;
    logic [1:0]    trap_slot;
    logic          ret_vld;
    logic [1:0]    ret_slot;
    logic [2:0]    ret_dst;
    logic          pad_armed, swchk_req, illegal_squash;
    logic [CW-1:0] swchk_cause;
    logic [XW-1:0] swchk_tval;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    landing_pad_tracker #(.CAUSE_W(CW), .XLEN(XW)) u_dut (.*);

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        retire_vld = 0; retire_ind_jump = 0;
        insn_vld = 0; insn_is_lpad = 0; insn_fetch_fault = 0; insn_illegal = 0;
        trap_vld = 0; trap_slot = 0; ret_vld = 0; ret_slot = 0; ret_dst = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic set_armed(input bit a);
        if (a) begin
            lpe_en = 5'h1F; cur_mode = 3'd2;
            retire_vld = 1; retire_ind_jump = 1;
        end else begin
            insn_vld = 1; insn_is_lpad = 1;
        end
        step();
    endtask

    initial begin
        #(200000 * 8);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(); cur_mode = 3'd2; lpe_en = 5'h1F;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(pad_armed, 0, "R1 armed after reset");
        insn_vld = 1; #1;
        chk(swchk_req, 0, "R1 no request after reset");
        idle();
        for (int s = 0; s < 4; s++) begin
            ret_vld = 1; ret_slot = 2'(s); ret_dst = 3'd2; lpe_en = 5'h1F;
            step();
            chk(pad_armed, 0, $sformatf("R1 copy %0d zero", s));
        end

        // R2, R3: arming per mode and enable, then landing-pad clear
        for (int m = 0; m < 8; m++) begin
            for (int e = 0; e < 2; e++) begin
                bit exp_arm;
                exp_arm = (m < 5) && (e == 1);
                cur_mode = 3'(m);
                lpe_en = (m < 5) ? (e ? 5'(1 << m) : (5'h1F & ~5'(1 << m))) : (e ? 5'h1F : 5'h00);
                retire_vld = 1; retire_ind_jump = 1;
                step();
                chk(pad_armed, 64'(exp_arm), $sformatf("R2 mode %0d en %0d", m, e));
                insn_vld = 1; insn_is_lpad = 1; #1;
                chk(swchk_req, 0, "R3 pad gives no request");
                step();
                chk(pad_armed, 0, "R3 pad clears");
            end
        end

        // R4, R5: slot behaviour over all input combinations
        for (int k = 0; k < 16; k++) begin
            bit a, f, il, l, er;
            a = k[0]; f = k[1]; il = k[2]; l = k[3];
            set_armed(a);
            insn_vld = 1; insn_is_lpad = l; insn_fetch_fault = f; insn_illegal = il;
            #1;
            er = a && !l && !f;
            chk(swchk_req, 64'(er), $sformatf("R4 R5 request combo %0d", k));
            chk(illegal_squash, 64'(er && il), $sformatf("R5 squash combo %0d", k));
            if (er) begin
                chk(swchk_cause, 18, "R4 cause");
                chk(swchk_tval, 2, "R4 tval");
            end
            idle();
            set_armed(0);
        end

        // R6..R9: save, restore, and clear per slot
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 2; a++) begin
                for (int d = 0; d < 5; d++) begin
                    for (int e = 0; e < 2; e++) begin
                        set_armed(a[0]);
                        trap_vld = 1; trap_slot = 2'(s);
                        step();
                        chk(pad_armed, 0, (s == 3) ? "R7 debug entry clears" : "R6 trap clears");
                        ret_vld = 1; ret_slot = 2'(s); ret_dst = 3'(d);
                        lpe_en = e ? 5'h1F : (5'h1F & ~5'(1 << d));
                        step();
                        chk(pad_armed, 64'(a[0] && e[0]),
                            $sformatf("R8 R6 R7 slot %0d a %0d dst %0d en %0d", s, a, d, e));
                        set_armed(0);
                        ret_vld = 1; ret_slot = 2'(s); ret_dst = 3'd2; lpe_en = 5'h1F;
                        step();
                        chk(pad_armed, 0, "R9 copy cleared");
                    end
                end
            end
        end

        // R10: same-cycle precedence
        set_armed(1);
        trap_vld = 1; trap_slot = 2'd1; retire_vld = 1; retire_ind_jump = 1;
        step();
        chk(pad_armed, 0, "R10 trap beats jump");
        ret_vld = 1; ret_slot = 2'd1; ret_dst = 3'd1; lpe_en = 5'h1F;
        retire_vld = 1; retire_ind_jump = 1; cur_mode = 3'd1;
        step();
        chk(pad_armed, 1, "R10 trap saved live bit");
        set_armed(0);
        ret_vld = 1; ret_slot = 2'd1; ret_dst = 3'd1;
        retire_vld = 1; retire_ind_jump = 1;
        step();
        chk(pad_armed, 0, "R10 return beats jump");
        set_armed(1);
        retire_vld = 1; retire_ind_jump = 1; insn_vld = 1; insn_is_lpad = 1;
        step();
        chk(pad_armed, 1, "R10 jump beats pad");
        trap_vld = 1; trap_slot = 2'd2; ret_vld = 1; ret_slot = 2'd2; ret_dst = 3'd4;
        step();
        ret_vld = 1; ret_slot = 2'd2; ret_dst = 3'd4;
        step();
        chk(pad_armed, 1, "R10 trap beats return");
        set_armed(0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule